// File: doc/BRIEF.md
# Predicated vector element sequencer

This block expands a single scalar operation into a run of element operations. When it is started it latches a length, a predicate mask and, for each of three operands (one destination and two sources), a base register number and a flag that says whether that operand is vectorised. It then walks the elements in order from index zero. For each element it produces a destination register number and two source register numbers. Each operand's register number is its base plus its own element offset.

The offset of a vectorised operand follows the element index. A scalar operand keeps offset zero for the whole run, so it names the same register on every step. An element whose predicate bit is clear produces no issue record, but all offsets still move past it. The records leave through a valid/ready handshake, and a one-cycle done pulse marks the end of the run.

The consumer treats each accepted record as an ordinary scalar operation. Register file access and the arithmetic itself happen outside the block.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `iss_valid` and `done` are both 0.
- R2: Elements are visited in ascending order from 0 to the latched length minus 1. `iss_elem` carries the index of the element on offer.
- R3: A record is offered for element i only when bit i of the latched `pred_mask` is 1. Bit 0 belongs to element 0.
- R4: The destination offset equals the element index when `rd_vec` was 1 at start. When `rd_vec` was 0, the offset is 0 for every element.
- R5: Each source offset follows the element index or stays at 0, depending only on its own flag (`ra_vec` for A, `rb_vec` for B). The other operands' flags have no effect on it.
- R6: Every presented register number is base plus offset, modulo 128 (7-bit wrap).
- R7: An element with a clear predicate bit is skipped without a handshake, but every vectorised offset still advances past it.
- R8: A start with length 0 offers no record, and `done` is 1 in the cycle right after the start edge.
- R9: A start that arrives while a run is in progress is ignored. It does not restart the run, and it does not change the run's length, mask, bases or flags.
- R10: While `iss_valid` is 1 and `iss_ready` is 0, `iss_valid` stays 1 and all record fields stay unchanged.
- R11: `done` is a one-cycle pulse. It rises after the last element has been handed over or skipped, and while it is high no record is on offer.
- R12: A length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; latches all configuration inputs when idle |
| vl | input | 7 | Number of elements (0 to 64, larger values clamp) |
| pred_mask | input | 64 | Per-element predicate, bit i for element i |
| rd_base | input | 7 | Destination base register number |
| ra_base | input | 7 | Source A base register number |
| rb_base | input | 7 | Source B base register number |
| rd_vec | input | 1 | Destination is vectorised |
| ra_vec | input | 1 | Source A is vectorised |
| rb_vec | input | 1 | Source B is vectorised |
| iss_ready | input | 1 | Consumer accepts the offered record |
| iss_valid | output | 1 | A record is on offer |
| iss_elem | output | 6 | Element index of the record |
| iss_rd | output | 7 | Destination register number |
| iss_ra | output | 7 | Source A register number |
| iss_rb | output | 7 | Source B register number |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench drives sparse masks that include masked-off elements at the start and end of a run. A design that froze offsets on skipped elements would then present register numbers that lag the element index. It also drives mixed vectorised and scalar flags, which expose a design that advances one operand under another operand's flag or lets a scalar operand drift. Runs under periodic backpressure catch fields that change, or elements that are lost, while the consumer stalls. A zero length, a length above 64, a base near 127 and a second start pulse in mid-run cover the premature or missing done, the counter overflow, the missing register wrap and the restarted run.

// File: rtl/vseq_pkg.sv
// Package: shared types for the element sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package vseq_pkg;
    // Run state of the element walker.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Operand slots, used as generate indices in the top module.
    localparam int OPND_RD  = 0;
    localparam int OPND_RA  = 1;
    localparam int OPND_RB  = 2;
    localparam int OPND_NUM = 3;
endpackage

// File: rtl/vseq_ctrl.sv
// Module: vseq_ctrl
// Walks the element index from 0 up to the latched length minus one. It
// skips elements whose predicate bit is clear and waits on the consumer for
// the others. It latches the length (clamped to VLMAX) and the mask on an
// accepted start, and raises a one-cycle done at the end of a run.
// Assumes: start is only acted on when idle; VLMAX is a power of two.
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int VLW   = $clog2(VLMAX + 1),
    parameter int IW    = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [VLMAX-1:0] pred_mask,
    input  logic             iss_ready,
    output logic             load,
    output logic             advance,
    output logic             busy,
    output logic             active,
    output logic             done,
    output logic [IW-1:0]    elem,
    output logic [VLW-1:0]   cfg_vl,
    output logic [VLMAX-1:0] cfg_mask
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(VLMAX);

    seq_state_e     state_q;
    logic [VLW-1:0] vl_eff;
    logic           last_elem;

    // Clamp the requested length to the supported maximum.
    always_comb vl_eff = (vl > VL_CAP) ? VL_CAP : vl;

    // Decode the handshake-level controls from the current state.
    always_comb begin
        busy      = (state_q == ST_RUN);
        load      = start && !busy;
        active    = busy && cfg_mask[elem];
        advance   = busy && (!cfg_mask[elem] || iss_ready);
        last_elem = (VLW'(elem) == (cfg_vl - VLW'(1)));
    end

    // State, element counter, latched config and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cfg_vl   <= '0;
            cfg_mask <= '0;
            elem     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cfg_vl   <= vl_eff;
                cfg_mask <= pred_mask;
                elem     <= '0;
                if (vl_eff != '0) begin
                    state_q <= ST_RUN;
                end else begin
                    done <= 1'b1;
                end
            end else if (advance) begin
                if (last_elem) begin
                    state_q <= ST_IDLE;
                    elem    <= '0;
                    done    <= 1'b1;
                end else begin
                    elem <= elem + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vseq_offset.sv
// Module: vseq_offset
// Keeps one operand's base register and vectorised flag for the run, plus
// its element offset. The offset is cleared on load and steps on every
// element advance, but only when the operand is vectorised. The register
// number is base plus offset with RW-bit wrap.
// Assumes: load and advance are never high together.
module vseq_offset #(
    parameter int RW = 7,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [RW-1:0] base_in,
    input  logic          vec_in,
    output logic [RW-1:0] regnum
);
    logic [RW-1:0] base_q;
    logic          vec_q;
    logic [OW-1:0] off_q;

    // Latch operand config on load and step the offset on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vec_q  <= 1'b0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            vec_q  <= vec_in;
            off_q  <= '0;
        end else if (advance && vec_q) begin
            off_q <= off_q + OW'(1);
        end
    end

    // Form the register number with modular wrap.
    always_comb regnum = base_q + RW'(off_q);
endmodule

// File: rtl/vec_elem_seq.sv
// Module: vec_elem_seq (top)
// Expands one scalar operation into a run of predicated element records,
// one destination and two source register numbers each, handed out over a
// valid/ready port. One offset unit per operand is generated.
// Assumes: the consumer holds nothing back except through iss_ready.
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int RW    = 7,
    parameter int VLW   = $clog2(VLMAX + 1),
    parameter int IW    = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [VLMAX-1:0] pred_mask,
    input  logic [RW-1:0]    rd_base,
    input  logic [RW-1:0]    ra_base,
    input  logic [RW-1:0]    rb_base,
    input  logic             rd_vec,
    input  logic             ra_vec,
    input  logic             rb_vec,
    input  logic             iss_ready,
    output logic             iss_valid,
    output logic [IW-1:0]    iss_elem,
    output logic [RW-1:0]    iss_rd,
    output logic [RW-1:0]    iss_ra,
    output logic [RW-1:0]    iss_rb,
    output logic             done
);
    logic             load_w;
    logic             adv_w;
    logic             busy_w;
    logic             active_w;
    logic [IW-1:0]    elem_w;
    logic [VLW-1:0]   cfg_vl_w;
    logic [VLMAX-1:0] cfg_mask_w;
    logic [RW-1:0]    base_arr [OPND_NUM];
    logic             vec_arr  [OPND_NUM];
    logic [RW-1:0]    reg_arr  [OPND_NUM];

    // Gather per-operand inputs into slot-indexed arrays.
    always_comb begin
        base_arr[OPND_RD] = rd_base;
        base_arr[OPND_RA] = ra_base;
        base_arr[OPND_RB] = rb_base;
        vec_arr[OPND_RD]  = rd_vec;
        vec_arr[OPND_RA]  = ra_vec;
        vec_arr[OPND_RB]  = rb_vec;
    end

    vseq_ctrl #(
        .VLMAX (VLMAX),
        .VLW   (VLW),
        .IW    (IW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl        (vl),
        .pred_mask (pred_mask),
        .iss_ready (iss_ready),
        .load      (load_w),
        .advance   (adv_w),
        .busy      (busy_w),
        .active    (active_w),
        .done      (done),
        .elem      (elem_w),
        .cfg_vl    (cfg_vl_w),
        .cfg_mask  (cfg_mask_w)
    );

    for (genvar g = 0; g < OPND_NUM; g++) begin : g_opnd
        vseq_offset #(
            .RW (RW),
            .OW (IW)
        ) u_off (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_w),
            .advance (adv_w),
            .base_in (base_arr[g]),
            .vec_in  (vec_arr[g]),
            .regnum  (reg_arr[g])
        );
    end

    // Drive the issue record from the walker state.
    always_comb begin
        iss_valid = active_w;
        iss_elem  = elem_w;
        iss_rd    = reg_arr[OPND_RD];
        iss_ra    = reg_arr[OPND_RA];
        iss_rb    = reg_arr[OPND_RB];
    end
endmodule

// File: rtl/vseq_chk.sv
// Module: vseq_chk
// Temporal checks on the sequencer's port behaviour and latched config.
// It is attached to every instance of the top module by the bind below.
// Assumes: synchronous active-low reset on rst_n.
module vseq_chk #(
    parameter int VLMAX = 64,
    parameter int RW    = 7,
    parameter int VLW   = $clog2(VLMAX + 1),
    parameter int IW    = $clog2(VLMAX)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl,
    input logic             busy,
    input logic             done,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [IW-1:0]    iss_elem,
    input logic [RW-1:0]    iss_rd,
    input logic [RW-1:0]    iss_ra,
    input logic [RW-1:0]    iss_rb,
    input logic [VLW-1:0]   cfg_vl,
    input logic [VLMAX-1:0] cfg_mask
);
    a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_valid);

    a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> ($stable(iss_elem) && $stable(iss_rd)
                                       && $stable(iss_ra) && $stable(iss_rb)));

    a_r3_pred_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> cfg_mask[iss_elem]);

    a_r2_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (VLW'(iss_elem) < cfg_vl));

    a_r2_elem_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (!iss_valid || (iss_elem > $past(iss_elem))));

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!iss_valid && !busy));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r8_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vl == '0)) |=> (done && !busy));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(cfg_vl) && $stable(cfg_mask)));
endmodule

bind vec_elem_seq vseq_chk #(
    .VLMAX (VLMAX),
    .RW    (RW),
    .VLW   (VLW),
    .IW    (IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl        (vl),
    .busy      (busy_w),
    .done      (done),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_elem  (iss_elem),
    .iss_rd    (iss_rd),
    .iss_ra    (iss_ra),
    .iss_rb    (iss_rb),
    .cfg_vl    (cfg_vl_w),
    .cfg_mask  (cfg_mask_w)
);

// File: tb/vec_elem_seq_tb_top.sv
// Directed bench for vec_elem_seq: one task per scenario, each checking
// its own results against values computed from the requirements.
module vec_elem_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [63:0] pred_mask = '0;
    logic [6:0]  rd_base = '0;
    logic [6:0]  ra_base = '0;
    logic [6:0]  rb_base = '0;
    logic        rd_vec = 1'b0;
    logic        ra_vec = 1'b0;
    logic        rb_vec = 1'b0;
    logic        iss_ready = 1'b0;
    logic        iss_valid;
    logic [5:0]  iss_elem;
    logic [6:0]  iss_rd;
    logic [6:0]  iss_ra;
    logic [6:0]  iss_rb;
    logic        done;

    int checks = 0;
    int errors = 0;
    int exp_e [64];

    always #10 clk = ~clk;

    vec_elem_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl        (vl),
        .pred_mask (pred_mask),
        .rd_base   (rd_base),
        .ra_base   (ra_base),
        .rb_base   (rb_base),
        .rd_vec    (rd_vec),
        .ra_vec    (ra_vec),
        .rb_vec    (rb_vec),
        .iss_ready (iss_ready),
        .iss_valid (iss_valid),
        .iss_elem  (iss_elem),
        .iss_rd    (iss_rd),
        .iss_ra    (iss_ra),
        .iss_rb    (iss_rb),
        .done      (done)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // Start one run, consume it, and compare every record with the model.
    task automatic run_seq(input int v, input logic [63:0] m,
                           input int bd, input int ba, input int bb,
                           input bit vd, input bit va, input bit vb,
                           input bit backp, input bit poke, input string tag);
        int eff;
        int n_exp;
        int k;
        int e;
        int done_cyc;
        bit stall;
        int p_el, p_rd, p_ra, p_rb;
        eff = (v > 64) ? 64 : v;
        n_exp = 0;
        for (int i = 0; i < eff; i++) begin
            if (m[i]) begin
                exp_e[n_exp] = i;
                n_exp++;
            end
        end
        @(negedge clk);
        vl = 7'(v); pred_mask = m;
        rd_base = 7'(bd); ra_base = 7'(ba); rb_base = 7'(bb);
        rd_vec = vd; ra_vec = va; rb_vec = vb;
        start = 1'b1; iss_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        k = 0; done_cyc = -1; stall = 1'b0;
        p_el = 0; p_rd = 0; p_ra = 0; p_rb = 0;
        for (int cyc = 0; cyc < 400 && done_cyc < 0; cyc++) begin
            iss_ready = backp ? ((cyc % 3) != 0) : 1'b1;
            if (poke && cyc == 1) begin
                start = 1'b1; vl = 7'd3; pred_mask = '1;
                rd_base = 7'd90; ra_base = 7'd91; rb_base = 7'd92;
                rd_vec = ~vd; ra_vec = ~va; rb_vec = ~vb;
            end else begin
                start = 1'b0;
            end
            if (stall) begin
                chk({tag, " R10 valid held"}, int'(iss_valid), 1);
                chk({tag, " R10 elem held"}, int'(iss_elem), p_el);
                chk({tag, " R10 rd held"}, int'(iss_rd), p_rd);
                chk({tag, " R10 ra held"}, int'(iss_ra), p_ra);
                chk({tag, " R10 rb held"}, int'(iss_rb), p_rb);
            end
            if (done) begin
                done_cyc = cyc;
                chk({tag, " R11 no record during done"}, int'(iss_valid), 0);
            end else if (iss_valid) begin
                if (k >= n_exp) begin
                    chk({tag, " R3 unexpected extra record"}, 1, 0);
                end else begin
                    e = exp_e[k];
                    chk({tag, " R2 R3 element index"}, int'(iss_elem), e);
                    chk({tag, " R4 R6 rd"}, int'(iss_rd), (bd + (vd ? e : 0)) % 128);
                    chk({tag, " R5 R7 ra"}, int'(iss_ra), (ba + (va ? e : 0)) % 128);
                    chk({tag, " R5 R7 rb"}, int'(iss_rb), (bb + (vb ? e : 0)) % 128);
                end
                if (iss_ready) k++;
            end
            stall = iss_valid && !iss_ready;
            p_el = int'(iss_elem); p_rd = int'(iss_rd);
            p_ra = int'(iss_ra); p_rb = int'(iss_rb);
            @(negedge clk);
        end
        start = 1'b0;
        chk({tag, " R3 records handed over"}, k, n_exp);
        chk({tag, " R11 done seen"}, int'(done_cyc >= 0), 1);
        if (eff == 0) chk({tag, " R8 done right after start"}, done_cyc, 0);
        chk({tag, " R11 done lasts one cycle"}, int'(done), 0);
        chk({tag, " R11 idle after done"}, int'(iss_valid), 0);
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk({tag, " R9 no restarted run"}, int'(iss_valid || done), 0);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", int'(iss_valid), 0);
        chk("R1 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid low after reset", int'(iss_valid), 0);
        chk("R1 done low after reset", int'(done), 0);
    endtask

    task automatic t_all_vector();
        run_seq(8, 64'hFF, 10, 20, 30, 1, 1, 1, 0, 0, "all-vector R2");
    endtask

    task automatic t_scalar_mix();
        run_seq(6, 64'h3F, 40, 50, 60, 0, 1, 0, 0, 0, "scalar-dest R4 R5");
        run_seq(5, 64'h1F, 3, 4, 5, 1, 0, 1, 0, 0, "scalar-srcA R5");
    endtask

    task automatic t_predicate();
        run_seq(12, 64'h0A5A, 16, 32, 48, 1, 1, 1, 0, 0, "sparse R3 R7");
        run_seq(10, 64'h0000_0000_0000_0100, 0, 64, 100, 1, 1, 0, 0, 0, "one-bit R7");
        run_seq(7, 64'h0, 1, 2, 3, 1, 1, 1, 0, 0, "all-off R3 R7");
    endtask

    task automatic t_zero_length();
        run_seq(0, '1, 1, 2, 3, 1, 1, 1, 0, 0, "zero R8");
    endtask

    task automatic t_backpressure();
        run_seq(9, 64'h1ED, 70, 80, 90, 1, 0, 1, 1, 0, "stall R10");
    endtask

    task automatic t_busy_start();
        run_seq(6, 64'h2D, 5, 6, 7, 1, 1, 0, 0, 1, "busy-start R9");
    endtask

    task automatic t_wrap();
        run_seq(5, 64'h1F, 126, 125, 127, 1, 1, 1, 0, 0, "wrap R6");
    endtask

    task automatic t_clamp();
        run_seq(100, '1, 0, 60, 64, 1, 1, 1, 0, 0, "clamp R12");
        run_seq(64, 64'h8000_0000_0000_0001, 2, 3, 4, 1, 0, 1, 1, 0, "full-length R12");
    endtask

    initial begin
        t_reset();
        t_all_vector();
        t_scalar_mix();
        t_predicate();
        t_zero_length();
        t_backpressure();
        t_busy_start();
        t_wrap();
        t_clamp();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule